// File: doc/BRIEF.md
# Standby Mode Power Controller

This block sequences a small microcontroller core between normal execution and two low-power states. A light sleep gates only the CPU clock. A deep sleep also switches off the main oscillator. Each state is entered by a one-cycle strobe from the instruction decoder. The controller drives the CPU clock enable and the main oscillator enable. It also drives one run qualifier per peripheral group: the interval/watchdog timer, the serial port, each timer/event counter, the watch timer, the display driver and each external interrupt line. A peripheral may advance only while its qualifier is high. Each qualifier depends on the current state and on the clock source that software has chosen for that peripheral.

Wake-up is level-sensitive. The controller ANDs each peripheral's interrupt request with its enable bit and with that peripheral's run qualifier, then ORs the results. Any active term ends a sleep. After a deep sleep, the CPU clock stays gated until the oscillator reports that it is stable. A synchronous active-low reset returns the block to run from any state.

Top module: `standby_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next state is run. Run reports `mode_o` = 00, `cpu_clk_en_o` = 1, `osc_en_o` = NOT `main_osc_off`, and every run qualifier and external line qualifier = 1.
- R2: In run, `halt_req` without a valid deep-sleep request enters light sleep on the next cycle. Light sleep reports `mode_o` = 01, `cpu_clk_en_o` = 0, `osc_en_o` = NOT `main_osc_off`.
- R3: In run, `stop_req` with `cpu_on_main` = 1 enters deep sleep on the next cycle and takes priority over `halt_req` in the same cycle. Deep sleep reports `mode_o` = 10, `cpu_clk_en_o` = 0, `osc_en_o` = 0.
- R4: `stop_req` while `cpu_on_main` = 0 is ignored. The block stays in run, or enters light sleep if `halt_req` is also high.
- R5: The wake bus has this bit order: [0] interval/watchdog timer, [1] serial, [2+:NTMR] timer/event counters, [2+NTMR] watch timer, [3+NTMR+:NEXT] external lines. While asleep, if any bit of `irq_req & irq_en & qualifier` is 1, light sleep returns to run and deep sleep moves to settling on the next cycle.
- R6: Settling reports `mode_o` = 00 with `cpu_clk_en_o` = 0, `osc_en_o` = NOT `main_osc_off`, and all qualifiers = 1. It becomes run on the cycle after `osc_stable` is sampled high.
- R7: `run_itw_o` is 0 in deep sleep, NOT `main_osc_off` in light sleep, and 1 otherwise. `wdt_rst_o` = `wdt_mode` AND `wdt_ovf` AND `run_itw_o`.
- R8: In deep sleep, `run_sio_o` = `ext_sck_sel` and `run_tmr_o[i]` = `tmr_ext_sel[i]`. In light sleep, each of them is also 1 when `main_osc_off` = 0.
- R9: In deep sleep, `run_wt_o` = `wt_sel_xt` and `run_lcd_o` = `lcd_sel_xt`. Both are 1 in light sleep.
- R10: In deep sleep, `run_ext_o[0]` = `int0_nf_bypass` and the other lines are 1. All lines are 1 in light sleep.
- R11: `halt_req` and `stop_req` have no effect outside run.
- R12: A low `rst_n` returns the block to run from light sleep, deep sleep or settling after one clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| halt_req | input | 1 | Light-sleep entry strobe |
| stop_req | input | 1 | Deep-sleep entry strobe |
| cpu_on_main | input | 1 | 1 when the CPU runs from the main clock |
| osc_stable | input | 1 | Main oscillator settled |
| main_osc_off | input | 1 | Software has stopped the main oscillator |
| irq_req | input | NSRC | Interrupt requests in wake-bus order |
| irq_en | input | NSRC | Interrupt enables in wake-bus order |
| ext_sck_sel | input | 1 | Serial port clocked from its external pin |
| tmr_ext_sel | input | NTMR | Timer i counts its external pin |
| wt_sel_xt | input | 1 | Watch timer on the low-frequency crystal |
| lcd_sel_xt | input | 1 | Display driver on the low-frequency crystal |
| int0_nf_bypass | input | 1 | Line 0 noise filter bypassed |
| wdt_mode | input | 1 | Timer in watchdog mode |
| wdt_ovf | input | 1 | Timer overflow |
| mode_o | output | 2 | 00 run, 01 light sleep, 10 deep sleep |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| osc_en_o | output | 1 | Main oscillator enable |
| run_itw_o | output | 1 | Interval/watchdog timer qualifier |
| run_sio_o | output | 1 | Serial port qualifier |
| run_tmr_o | output | NTMR | Timer/event counter qualifiers |
| run_wt_o | output | 1 | Watch timer qualifier |
| run_lcd_o | output | 1 | Display driver qualifier |
| run_ext_o | output | NEXT | External interrupt line qualifiers |
| wdt_rst_o | output | 1 | Watchdog-forced reset |

## Verification
The bench tries a deep-sleep strobe while the CPU runs on the subsystem clock. A design that skipped this check would kill the oscillator under a CPU that still needs it. It raises requests from peripherals that are frozen in the current state, such as a filtered line 0 or a pin-less timer in deep sleep. A design that did not mask these would wake up falsely. It also holds `osc_stable` low after a deep-sleep wake, where a design that released the clock early would run the CPU on an unsettled oscillator. Finally, it sends strobes that arrive while asleep or together with a reset, which a careless design would act on.

// File: rtl/stby_pkg.sv
// Shared state encoding for the standby controller.
// The low two bits of a sleep state double as the reported mode code.
package stby_pkg;
    typedef enum logic [1:0] {
        ST_RUN    = 2'b00,
        ST_HALT   = 2'b01,
        ST_STOP   = 2'b10,
        ST_SETTLE = 2'b11
    } stby_state_e;

    localparam logic [1:0] MODE_RUN = 2'b00;
endpackage

// File: rtl/stby_fsm.sv
// State register and sequencing for run, light sleep, deep sleep and settling.
// Assumes the entry strobes come from the instruction decoder, which issues
// them only while the CPU clock is running.
module stby_fsm
    import stby_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        halt_req,
    input  logic        stop_req,
    input  logic        cpu_on_main,
    input  logic        wake,
    input  logic        osc_stable,
    output stby_state_e state
);
    stby_state_e nxt;

    // Next-state selection; a deep-sleep request is dropped on the sub clock.
    always_comb begin
        nxt = state;
        unique case (state)
            ST_RUN: begin
                if (stop_req && cpu_on_main) nxt = ST_STOP;
                else if (halt_req)          nxt = ST_HALT;
            end
            ST_HALT:   if (wake)       nxt = ST_RUN;
            ST_STOP:   if (wake)       nxt = ST_SETTLE;
            ST_SETTLE: if (osc_stable) nxt = ST_RUN;
            default:                   nxt = ST_RUN;
        endcase
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= nxt;
    end
endmodule

// File: rtl/stby_qual.sv
// Clock gating enables and peripheral run qualifiers.
// Purely combinational. Assumes the clock-source selects are static while asleep.
module stby_qual
    import stby_pkg::*;
#(
    parameter int NTMR = 3,
    parameter int NEXT = 4
) (
    input  stby_state_e      state,
    input  logic             main_osc_off,
    input  logic             ext_sck_sel,
    input  logic [NTMR-1:0]  tmr_ext_sel,
    input  logic             wt_sel_xt,
    input  logic             lcd_sel_xt,
    input  logic             int0_nf_bypass,
    input  logic             wdt_mode,
    input  logic             wdt_ovf,
    output logic [1:0]       mode,
    output logic             cpu_clk_en,
    output logic             osc_en,
    output logic             run_itw,
    output logic             run_sio,
    output logic [NTMR-1:0]  run_tmr,
    output logic             run_wt,
    output logic             run_lcd,
    output logic [NEXT-1:0]  run_ext,
    output logic             wdt_rst
);
    logic in_halt, in_stop, main_live;

    // State decode and main oscillator status.
    always_comb begin
        in_halt    = (state == ST_HALT);
        in_stop    = (state == ST_STOP);
        main_live  = !main_osc_off;
        mode       = (state == ST_SETTLE) ? MODE_RUN : state;
        cpu_clk_en = (state == ST_RUN);
        osc_en     = main_live && !in_stop;
    end

    // Qualifiers for the single-instance peripherals.
    always_comb begin
        if (in_stop) begin
            run_itw = 1'b0;
            run_sio = ext_sck_sel;
            run_wt  = wt_sel_xt;
            run_lcd = lcd_sel_xt;
        end else if (in_halt) begin
            run_itw = main_live;
            run_sio = ext_sck_sel || main_live;
            run_wt  = 1'b1;
            run_lcd = 1'b1;
        end else begin
            run_itw = 1'b1;
            run_sio = 1'b1;
            run_wt  = 1'b1;
            run_lcd = 1'b1;
        end
        wdt_rst = wdt_mode && wdt_ovf && run_itw;
    end

    // One qualifier per timer/event counter.
    for (genvar t = 0; t < NTMR; t++) begin : g_tmr
        always_comb begin
            if (in_stop)      run_tmr[t] = tmr_ext_sel[t];
            else if (in_halt) run_tmr[t] = tmr_ext_sel[t] || main_live;
            else              run_tmr[t] = 1'b1;
        end
    end

    // External lines: only line 0 depends on its noise filter in deep sleep.
    for (genvar e = 0; e < NEXT; e++) begin : g_ext
        if (e == 0) begin : g_filt
            always_comb run_ext[e] = in_stop ? int0_nf_bypass : 1'b1;
        end else begin : g_plain
            always_comb run_ext[e] = 1'b1;
        end
    end
endmodule

// File: rtl/stby_wake.sv
// Wake detect: OR over requests that are enabled and come from running sources.
// Assumes requests are levels held until serviced.
module stby_wake #(
    parameter int NSRC = 10
) (
    input  logic [NSRC-1:0] irq_req,
    input  logic [NSRC-1:0] irq_en,
    input  logic [NSRC-1:0] src_live,
    output logic            wake
);
    // Masked reduction of the request bus.
    always_comb wake = |(irq_req & irq_en & src_live);
endmodule

// File: rtl/standby_ctrl.sv
// Top of the standby controller: sequencing, qualifiers and wake detect.
// Wake-bus order: itw, serial, timers, watch timer, external lines.
module standby_ctrl
    import stby_pkg::*;
#(
    parameter int NTMR = 3,
    parameter int NEXT = 4,
    localparam int NSRC = 3 + NTMR + NEXT
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            halt_req,
    input  logic            stop_req,
    input  logic            cpu_on_main,
    input  logic            osc_stable,
    input  logic            main_osc_off,
    input  logic [NSRC-1:0] irq_req,
    input  logic [NSRC-1:0] irq_en,
    input  logic            ext_sck_sel,
    input  logic [NTMR-1:0] tmr_ext_sel,
    input  logic            wt_sel_xt,
    input  logic            lcd_sel_xt,
    input  logic            int0_nf_bypass,
    input  logic            wdt_mode,
    input  logic            wdt_ovf,
    output logic [1:0]      mode_o,
    output logic            cpu_clk_en_o,
    output logic            osc_en_o,
    output logic            run_itw_o,
    output logic            run_sio_o,
    output logic [NTMR-1:0] run_tmr_o,
    output logic            run_wt_o,
    output logic            run_lcd_o,
    output logic [NEXT-1:0] run_ext_o,
    output logic            wdt_rst_o
);
    stby_state_e     state;
    logic            wake;
    logic [NSRC-1:0] src_live;

    stby_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .stop_req(stop_req),
        .cpu_on_main(cpu_on_main), .wake(wake), .osc_stable(osc_stable),
        .state(state)
    );

    stby_qual #(.NTMR(NTMR), .NEXT(NEXT)) u_qual (
        .state(state), .main_osc_off(main_osc_off), .ext_sck_sel(ext_sck_sel),
        .tmr_ext_sel(tmr_ext_sel), .wt_sel_xt(wt_sel_xt), .lcd_sel_xt(lcd_sel_xt),
        .int0_nf_bypass(int0_nf_bypass), .wdt_mode(wdt_mode), .wdt_ovf(wdt_ovf),
        .mode(mode_o), .cpu_clk_en(cpu_clk_en_o), .osc_en(osc_en_o),
        .run_itw(run_itw_o), .run_sio(run_sio_o), .run_tmr(run_tmr_o),
        .run_wt(run_wt_o), .run_lcd(run_lcd_o), .run_ext(run_ext_o),
        .wdt_rst(wdt_rst_o)
    );

    // Assemble the wake-bus qualifier vector in source order.
    always_comb src_live = {run_ext_o, run_wt_o, run_tmr_o, run_sio_o, run_itw_o};

    stby_wake #(.NSRC(NSRC)) u_wake (
        .irq_req(irq_req), .irq_en(irq_en), .src_live(src_live), .wake(wake)
    );
endmodule

// File: rtl/stby_checker.sv
// Protocol checks for the standby controller, bound into every instance.
module stby_checker #(
    parameter int NEXT = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            stop_req,
    input logic            cpu_on_main,
    input logic            main_osc_off,
    input logic            wake,
    input logic [1:0]      mode_o,
    input logic            cpu_clk_en_o,
    input logic            osc_en_o,
    input logic            run_itw_o,
    input logic [NEXT-1:0] run_ext_o
);
    AST_RESET_TO_RUN: assert property (@(posedge clk)
        !rst_n |=> (mode_o == 2'b00)); // R12

    AST_HALT_GATING: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'b01) |-> (!cpu_clk_en_o && (osc_en_o == !main_osc_off))); // R2

    AST_STOP_GATING: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'b10) |-> (!cpu_clk_en_o && !osc_en_o)); // R3

    AST_SUB_CLK_NO_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'b00 && cpu_clk_en_o && stop_req && !cpu_on_main) |=> (mode_o != 2'b10)); // R4

    AST_HALT_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'b01 && wake) |=> (mode_o == 2'b00 && cpu_clk_en_o)); // R5

    AST_STOP_WAKE_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'b10 && wake) |=> (mode_o == 2'b00 && !cpu_clk_en_o)); // R6

    AST_STOP_ITW_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'b10) |-> !run_itw_o); // R7

    AST_STOP_EXT_LINES: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'b10) |-> (&run_ext_o[NEXT-1:1])); // R10
endmodule

bind standby_ctrl stby_checker #(.NEXT(NEXT)) u_chk (
    .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .cpu_on_main(cpu_on_main),
    .main_osc_off(main_osc_off), .wake(wake), .mode_o(mode_o),
    .cpu_clk_en_o(cpu_clk_en_o), .osc_en_o(osc_en_o), .run_itw_o(run_itw_o),
    .run_ext_o(run_ext_o)
);

// File: tb/tb_standby_ctrl.sv
`timescale 1ns/1ps
module tb_standby_ctrl;
    localparam int NTMR = 3;
    localparam int NEXT = 4;
    localparam int NSRC = 3 + NTMR + NEXT;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic halt_req = 0, stop_req = 0, cpu_on_main = 1, osc_stable = 0, main_osc_off = 0;
    logic [NSRC-1:0] irq_req = '0, irq_en = '0;
    logic ext_sck_sel = 0, wt_sel_xt = 0, lcd_sel_xt = 0, int0_nf_bypass = 0;
    logic wdt_mode = 0, wdt_ovf = 0;
    logic [NTMR-1:0] tmr_ext_sel = '0;
    logic [1:0] mode_o;
    logic cpu_clk_en_o, osc_en_o, run_itw_o, run_sio_o, run_wt_o, run_lcd_o, wdt_rst_o;
    logic [NTMR-1:0] run_tmr_o;
    logic [NEXT-1:0] run_ext_o;

    int checks = 0, errors = 0;
    logic [1:0] es = 2'b00;   // model state: 00 run, 01 halt, 10 stop, 11 settle
    bit valid = 0, done = 0;

    always #2.5 clk = ~clk;

    standby_ctrl #(.NTMR(NTMR), .NEXT(NEXT)) dut (.*);

    // Expected qualifier vector in wake-bus order.
    function automatic logic [NSRC-1:0] exp_q(input logic [1:0] s);
        logic mo = !main_osc_off;
        logic [NSRC-1:0] q = '1;
        if (s == 2'b01) begin
            q[0] = mo; q[1] = ext_sck_sel | mo; q[2+:NTMR] = tmr_ext_sel | {NTMR{mo}};
        end else if (s == 2'b10) begin
            q[0] = 1'b0; q[1] = ext_sck_sel; q[2+:NTMR] = tmr_ext_sel;
            q[2+NTMR] = wt_sel_xt; q[3+NTMR] = int0_nf_bypass;
        end
        return q;
    endfunction

    function automatic logic [1:0] exp_next(input logic [1:0] s);
        logic wk = |(irq_req & irq_en & exp_q(s));
        if (!rst_n) return 2'b00;
        case (s)
            2'b00: return (stop_req && cpu_on_main) ? 2'b10 : (halt_req ? 2'b01 : 2'b00);
            2'b01: return wk ? 2'b00 : 2'b01;
            2'b10: return wk ? 2'b11 : 2'b10;
            default: return osc_stable ? 2'b00 : 2'b11;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare all outputs against the model for the current state.
    task automatic check_all();
        logic [NSRC-1:0] q = exp_q(es);
        string mtag = (es == 2'b00) ? "R1" : (es == 2'b01) ? "R2" : (es == 2'b10) ? "R3" : "R6";
        check({mtag, " mode"}, 32'(mode_o), 32'((es == 2'b11) ? 2'b00 : es));
        check({mtag, " clk/osc"}, {cpu_clk_en_o, osc_en_o},
              {es == 2'b00, (es != 2'b10) && !main_osc_off});
        check("R7 itw/wdt", {run_itw_o, wdt_rst_o}, {q[0], wdt_mode & wdt_ovf & q[0]});
        check("R8 sio/tmr", {run_tmr_o, run_sio_o}, 32'(q[1+:NTMR+1]));
        check("R9 wt/lcd", {run_wt_o, run_lcd_o},
              {q[2+NTMR], (es == 2'b10) ? lcd_sel_xt : 1'b1});
        check("R10 ext", 32'(run_ext_o), 32'(q[3+NTMR+:NEXT]));
    endtask

    // One cycle: inputs already set at the falling edge.
    task automatic tick();
        #1;
        if (valid) check_all();
        @(posedge clk);
        es = exp_next(es);
        valid = 1;
        @(negedge clk);
    endtask

    task automatic idle();
        halt_req = 0; stop_req = 0; irq_req = '0; osc_stable = 0; rst_n = 1;
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        @(negedge clk);
        rst_n = 0; tick();
        #1 check("R1 reset mode", 32'(mode_o), 0);
        check("R1 reset clk", {cpu_clk_en_o, osc_en_o}, 2'b11);
        idle(); tick();

        // R4: deep-sleep strobe on subsystem clock is ignored
        cpu_on_main = 0; stop_req = 1; tick(); idle();
        #1 check("R4 stop ignored on sub clock", 32'(mode_o), 0);
        cpu_on_main = 0; stop_req = 1; halt_req = 1; tick(); idle();
        #1 check("R4 halt taken instead", 32'(mode_o), 1);
        // R11: strobes in light sleep have no effect
        cpu_on_main = 1; stop_req = 1; tick(); idle();
        #1 check("R11 stop in halt ignored", 32'(mode_o), 1);
        // R5: enabled serial request wakes light sleep
        irq_req[1] = 1; irq_en[1] = 1; tick(); idle();
        #1 check("R5 halt wake", {mode_o, cpu_clk_en_o}, 3'b001);
        // R3: stop priority over halt
        stop_req = 1; halt_req = 1; tick(); idle();
        #1 check("R3 stop priority", 32'(mode_o), 2);
        // R10: filtered line 0 cannot wake deep sleep
        int0_nf_bypass = 0; irq_req[3+NTMR] = 1; irq_en[3+NTMR] = 1; tick();
        #1 check("R10 filtered line0 no wake", 32'(mode_o), 2);
        // R5/R6: line 1 wakes into settling, held until oscillator stable
        irq_req = '0; irq_req[4+NTMR] = 1; irq_en[4+NTMR] = 1; tick(); idle();
        #1 check("R6 settle clk gated", {mode_o, cpu_clk_en_o, osc_en_o}, 4'b0001);
        tick();
        #1 check("R6 still settling", 32'(cpu_clk_en_o), 0);
        osc_stable = 1; tick(); idle();
        #1 check("R6 clock resumes", 32'(cpu_clk_en_o), 1);
        // R12: reset from deep sleep
        stop_req = 1; tick(); idle();
        rst_n = 0; stop_req = 1; tick(); idle();
        #1 check("R12 reset from stop", {mode_o, cpu_clk_en_o}, 3'b001);

        // Constrained random phase
        for (int i = 0; i < 4000; i++) begin
            rst_n        = ($urandom_range(99) != 0);
            halt_req     = ($urandom_range(9) == 0);
            stop_req     = ($urandom_range(9) == 0);
            cpu_on_main  = ($urandom_range(4) != 0);
            osc_stable   = ($urandom_range(3) == 0);
            main_osc_off = ($urandom_range(9) == 0);
            irq_en       = NSRC'($urandom);
            irq_req      = ($urandom_range(5) == 0) ? NSRC'(1 << $urandom_range(NSRC-1)) : '0;
            ext_sck_sel  = 1'($urandom); tmr_ext_sel = NTMR'($urandom);
            wt_sel_xt    = 1'($urandom); lcd_sel_xt = 1'($urandom);
            int0_nf_bypass = 1'($urandom);
            wdt_mode = 1'($urandom); wdt_ovf = ($urandom_range(3) == 0);
            tick();
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule